// File: doc/BRIEF.md
# Byte/Word Configurable ROM Read Port

This block is a clocked model of a read-only memory read interface. The memory holds 16-bit words. The block can present them either as whole 16-bit words or as single 8-bit bytes on the low lane. An organisation input picks the view. In word view the topmost data pin carries bit 15. In byte view that pin turns into an input and serves as the lowest byte-address bit: 0 selects the lower half of the addressed word and 1 selects the upper half. A signature request flag stands in for a raised voltage level on one address pin. While reading, it replaces memory data with fixed identification codes.

Two active-low controls gate the output. `ce_n` selects the device and acts as power control: when it is high the block is in standby. `oe_n` only gates the drivers. Every data bit has its own output-enable flag, so a wrapper can build real tri-state pads from it. The contents are written through a load port that only the testbench uses.

Each clock edge samples the controls and the address. A state register records the access kind as one of seven named states. The outputs follow that state and the registered read word. Every result therefore appears one clock after the inputs that caused it. The states are:
- `ST_STANDBY`: `ce_n` high.
- `ST_DISABLE`: selected, but `oe_n` high.
- `ST_WORD`: word read.
- `ST_BYTE_LO` and `ST_BYTE_HI`: byte reads of the lower or upper half.
- `ST_SIG_MFG` and `ST_SIG_DEV`: signature reads.

The next state depends only on the inputs sampled at the edge. Any state can therefore move to any other state in one cycle. The transitions are:
- Any state goes to standby when `ce_n`=1.
- Otherwise it goes to disable when `oe_n`=1.
- Otherwise it goes to a signature state when `sig_req`=1. `addr[0]` chooses between the two signature states.
- Otherwise it goes to `ST_WORD` when `wide_sel`=1.
- Otherwise it goes to `ST_BYTE_LO` or `ST_BYTE_HI`, according to `shared_in`.

Top module: `bwrom_port`

## Requirements
- R1: During reset and in the first cycle after reset, `standby`=1 and `dout_oe`=16'h0000.
- R2: If `ce_n`=1 at an edge, then after that edge `standby`=1 and `dout_oe`=16'h0000, whatever the other inputs are.
- R3: If `ce_n`=0 and `oe_n`=1 at an edge, then after that edge `standby`=0 and `dout_oe`=16'h0000 (output disable).
- R4: If `ce_n`=0, `oe_n`=0, `sig_req`=0 and `wide_sel`=1 at an edge, then after that edge `dout` equals the stored word at `addr` and `dout_oe`=16'hFFFF.
- R5: In byte view (`wide_sel`=0, `sig_req`=0, both enables low) with `shared_in`=0, then after the edge `dout[7:0]` equals bits 7:0 of the word at `addr` and `dout_oe`=16'h00FF.
- R6: In byte view with `shared_in`=1, then after the edge `dout[7:0]` equals bits 15:8 of the word at `addr` and `dout_oe`=16'h00FF.
- R7: Whenever `wide_sel`=0 was sampled, `dout_oe[15]`=0: the shared pin is never driven in byte view.
- R8: With both enables low and `sig_req`=1, `addr[0]`=0 gives `dout[7:0]`=8'h20 and `addr[0]`=1 gives `dout[7:0]`=8'hB2. Bits 14:8 are driven to 0. Bit 15 is driven to 0 in word view and left undriven in byte view. So `dout_oe` is 16'hFFFF in word view and 16'h7FFF in byte view.
- R9: During a signature read, `addr[ADDR_W-1:1]`, `shared_in` and the memory contents have no effect on `dout`.
- R10: `sig_req`=1 has no effect unless both `ce_n` and `oe_n` are low. In that case the block gives the standby or disable result of R2/R3.
- R11: Holding all inputs steady keeps `dout`, `dout_oe` and `standby` unchanged from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| shared_in | input | 1 | Value on the shared top data pin; in byte view it is the half-select address bit |
| wide_sel | input | 1 | 1 = word view, 0 = byte view |
| ce_n | input | 1 | Active-low chip enable / power control |
| oe_n | input | 1 | Active-low output enable |
| sig_req | input | 1 | Signature-mode request (stands for the raised level on address bit 9) |
| ld_we | input | 1 | Load port write strobe (bench only) |
| ld_addr | input | ADDR_W | Load port word address |
| ld_data | input | 16 | Load port word data |
| dout | output | 16 | Output data value for each pin |
| dout_oe | output | 16 | Per-bit drive enable; 0 means high-impedance |
| standby | output | 1 | High while the device is deselected |

## Verification
Every result (data, drive enables and standby) is due exactly one clock edge after the inputs that produce it are sampled. The bench changes inputs on the falling edge, waits for one rising edge, and samples the outputs on the following falling edge. That is the single-cycle point, and nothing is read earlier or later. Hold checks compare two consecutive falling-edge samples with steady inputs. Signature and gating checks change unrelated inputs between those same sampling points. The checker compares registered outputs against `$past` of the inputs, shifted by that same one edge.

// File: rtl/bwrom_pkg.sv
package bwrom_pkg;

    // Access kind recorded at each clock edge
    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_DISABLE = 3'd1,
        ST_WORD    = 3'd2,
        ST_BYTE_LO = 3'd3,
        ST_BYTE_HI = 3'd4,
        ST_SIG_MFG = 3'd5,
        ST_SIG_DEV = 3'd6
    } rd_state_e;

    // True for the two states that return identification codes
    function automatic logic is_sig(input rd_state_e s);
        return (s == ST_SIG_MFG) || (s == ST_SIG_DEV);
    endfunction

endpackage

// File: rtl/bwrom_store.sv
module bwrom_store #(
    parameter int ADDR_W = 8,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] cells [DEPTH];

    // Load port, used only to preset contents
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Synchronous read; holds its value while deselected
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/bwrom_decode.sv
module bwrom_decode
    import bwrom_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      wide_sel,
    input  logic      half_sel,
    input  logic      sig_req,
    input  logic      code_sel,
    output rd_state_e next_state
);
    // Priority: deselect, drive gating, signature, then organisation
    always_comb begin
        next_state = ST_STANDBY;
        if (ce_n) begin
            next_state = ST_STANDBY;
        end else if (oe_n) begin
            next_state = ST_DISABLE;
        end else if (sig_req) begin
            next_state = code_sel ? ST_SIG_DEV : ST_SIG_MFG;
        end else if (wide_sel) begin
            next_state = ST_WORD;
        end else begin
            next_state = half_sel ? ST_BYTE_HI : ST_BYTE_LO;
        end
    end

endmodule

// File: rtl/bwrom_lane.sv
module bwrom_lane
    import bwrom_pkg::*;
#(
    parameter int          DW       = 16,
    parameter logic [7:0]  MFG_CODE = 8'h20,
    parameter logic [7:0]  DEV_CODE = 8'hB2
) (
    input  rd_state_e     state,
    input  logic          wide_q,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] dout_oe,
    output logic          standby
);
    localparam int HALF   = DW / 2;
    localparam int TOPBIT = DW - 1;

    logic [DW-1:0] val;
    logic [DW-1:0] en_raw;

    // Output process: value and drive pattern per state
    always_comb begin
        val     = '0;
        en_raw  = '0;
        standby = 1'b0;
        unique case (state)
            ST_STANDBY: begin
                standby = 1'b1;
            end
            ST_DISABLE: begin
                en_raw = '0;
            end
            ST_WORD: begin
                val    = rd_word;
                en_raw = '1;
            end
            ST_BYTE_LO: begin
                val[HALF-1:0]    = rd_word[HALF-1:0];
                en_raw[HALF-1:0] = '1;
            end
            ST_BYTE_HI: begin
                val[HALF-1:0]    = rd_word[DW-1:HALF];
                en_raw[HALF-1:0] = '1;
            end
            ST_SIG_MFG: begin
                val[HALF-1:0] = MFG_CODE[HALF-1:0];
                en_raw        = '1;
            end
            ST_SIG_DEV: begin
                val[HALF-1:0] = DEV_CODE[HALF-1:0];
                en_raw        = '1;
            end
            default: begin
                standby = 1'b1;
            end
        endcase
    end

    // Per-pin drivers; the shared top pin is released in byte view
    for (genvar b = 0; b < DW; b++) begin : g_pin
        if (b == TOPBIT) begin : g_shared
            assign dout[b]    = val[b] & wide_q;
            assign dout_oe[b] = en_raw[b] & wide_q;
        end else begin : g_plain
            assign dout[b]    = val[b];
            assign dout_oe[b] = en_raw[b];
        end
    end

endmodule

// File: rtl/bwrom_port.sv
module bwrom_port
    import bwrom_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DW       = 16,
    parameter logic [7:0] MFG_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'hB2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              shared_in,
    input  logic              wide_sel,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              sig_req,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DW-1:0]     ld_data,
    output logic [DW-1:0]     dout,
    output logic [DW-1:0]     dout_oe,
    output logic              standby
);
    rd_state_e     state_q;
    rd_state_e     state_d;
    logic          wide_q;
    logic [DW-1:0] rd_word;

    bwrom_store #(
        .ADDR_W (ADDR_W),
        .DW     (DW)
    ) u_store (
        .clk     (clk),
        .wr_en   (ld_we),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_en   (~ce_n),
        .rd_addr (addr),
        .rd_data (rd_word)
    );

    bwrom_decode u_decode (
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .wide_sel   (wide_sel),
        .half_sel   (shared_in),
        .sig_req    (sig_req),
        .code_sel   (addr[0]),
        .next_state (state_d)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            wide_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            wide_q  <= wide_sel;
        end
    end

    bwrom_lane #(
        .DW       (DW),
        .MFG_CODE (MFG_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_lane (
        .state   (state_q),
        .wide_q  (wide_q),
        .rd_word (rd_word),
        .dout    (dout),
        .dout_oe (dout_oe),
        .standby (standby)
    );

endmodule

// File: rtl/bwrom_chk.sv
module bwrom_chk #(
    parameter int ADDR_W = 8,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              shared_in,
    input logic              wide_sel,
    input logic              ce_n,
    input logic              oe_n,
    input logic              sig_req,
    input logic [DW-1:0]     dout,
    input logic [DW-1:0]     dout_oe,
    input logic              standby
);
    localparam int HALF = DW / 2;

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_idle_chk: assert (standby && dout_oe == '0);
        end
    end

    // R2
    standby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ce_n)) |-> (standby && dout_oe == '0));

    // R3
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ce_n && oe_n)) |-> (!standby && dout_oe == '0));

    // R4
    word_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ce_n && !oe_n && !sig_req && wide_sel)) |-> (dout_oe == '1));

    // R5
    byte_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ce_n && !oe_n && !sig_req && !wide_sel))
        |-> ($countones(dout_oe) == HALF && dout_oe[HALF-1:0] == '1));

    // R7
    shared_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!wide_sel)) |-> !dout_oe[DW-1]);

    // R8
    sig_mfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ce_n && !oe_n && sig_req && !addr[0]))
        |-> (dout[7:0] == 8'h20 && dout[DW-1:HALF] == '0));

    // R8
    sig_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ce_n && !oe_n && sig_req && addr[0]))
        |-> (dout[7:0] == 8'hB2 && dout[DW-1:HALF] == '0));

endmodule

bind bwrom_port bwrom_chk #(
    .ADDR_W (ADDR_W),
    .DW     (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .shared_in (shared_in),
    .wide_sel  (wide_sel),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .sig_req   (sig_req),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .standby   (standby)
);

// File: tb/sim_bwrom_port.sv
`timescale 1ns/1ps
module sim_bwrom_port;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          shared_in = 1'b0;
    logic          wide_sel = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          sig_req = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] dout;
    logic [DW-1:0] dout_oe;
    logic          standby;

    logic [DW-1:0] ref_mem [DEPTH];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bwrom_port #(.ADDR_W(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .shared_in(shared_in),
        .wide_sel(wide_sel), .ce_n(ce_n), .oe_n(oe_n), .sig_req(sig_req),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .dout(dout), .dout_oe(dout_oe), .standby(standby)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, sample one rising edge later
    task automatic access(input logic c, input logic o, input logic w, input logic s,
                          input logic sh, input logic [AW-1:0] a);
        ce_n = c; oe_n = o; wide_sel = w; sig_req = s; shared_in = sh; addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(standby === 1'b1, "R1 standby", {31'b0, standby}, 1);
        chk(dout_oe === '0, "R1 oe", {16'b0, dout_oe}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(standby === 1'b1 && dout_oe === '0, "R1 first cycle", {16'b0, dout_oe}, 0);
    endtask

    task automatic t_load;
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = DW'((i * 16'h9E37) ^ 16'h5A5A ^ (i << 9));
            ld_we = 1'b1; ld_addr = AW'(i); ld_data = ref_mem[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
    endtask

    task automatic t_standby;
        access(1, 0, 1, 0, 0, 8'h11);
        chk(standby === 1'b1 && dout_oe === '0, "R2 standby", {15'b0, standby, dout_oe}, 32'h10000);
        access(1, 0, 0, 1, 1, 8'h01);
        chk(standby === 1'b1 && dout_oe === '0, "R2 standby sig", {15'b0, standby, dout_oe}, 32'h10000);
    endtask

    task automatic t_disable;
        access(0, 1, 1, 0, 0, 8'h22);
        chk(standby === 1'b0 && dout_oe === '0, "R3 disable", {15'b0, standby, dout_oe}, 0);
    endtask

    task automatic t_word;
        int list [4] = '{0, 1, 128, 255};
        foreach (list[k]) begin
            access(0, 0, 1, 0, 0, AW'(list[k]));
            chk(dout === ref_mem[list[k]] && dout_oe === 16'hFFFF, "R4 word",
                {dout, dout_oe}, {ref_mem[list[k]], 16'hFFFF});
        end
    endtask

    task automatic t_byte;
        int list [3] = '{3, 77, 254};
        foreach (list[k]) begin
            access(0, 0, 0, 0, 0, AW'(list[k]));
            chk(dout[7:0] === ref_mem[list[k]][7:0] && dout_oe === 16'h00FF, "R5 byte lo",
                {dout, dout_oe}, {8'h0, ref_mem[list[k]][7:0], 16'h00FF});
            chk(dout_oe[15] === 1'b0, "R7 shared pin lo", {31'b0, dout_oe[15]}, 0);
            access(0, 0, 0, 0, 1, AW'(list[k]));
            chk(dout[7:0] === ref_mem[list[k]][15:8] && dout_oe === 16'h00FF, "R6 byte hi",
                {dout, dout_oe}, {8'h0, ref_mem[list[k]][15:8], 16'h00FF});
            chk(dout_oe[15] === 1'b0, "R7 shared pin hi", {31'b0, dout_oe[15]}, 0);
        end
    endtask

    task automatic t_sig;
        access(0, 0, 1, 1, 0, 8'h00);
        chk(dout === 16'h0020 && dout_oe === 16'hFFFF, "R8 mfg word", {dout, dout_oe}, {16'h0020, 16'hFFFF});
        access(0, 0, 1, 1, 0, 8'h01);
        chk(dout === 16'h00B2 && dout_oe === 16'hFFFF, "R8 dev word", {dout, dout_oe}, {16'h00B2, 16'hFFFF});
        access(0, 0, 0, 1, 1, 8'h01);
        chk(dout[14:0] === 15'h00B2 && dout_oe === 16'h7FFF, "R8 dev byte", {dout, dout_oe}, {16'h00B2, 16'h7FFF});
    endtask

    task automatic t_sig_ignore;
        access(0, 0, 1, 1, 1, 8'hFE);
        chk(dout === 16'h0020, "R9 mfg ignores high addr", {16'b0, dout}, 16'h0020);
        access(0, 0, 1, 1, 0, 8'h5B);
        chk(dout === 16'h00B2, "R9 dev ignores high addr", {16'b0, dout}, 16'h00B2);
    endtask

    task automatic t_sig_gated;
        access(0, 1, 1, 1, 0, 8'h00);
        chk(standby === 1'b0 && dout_oe === '0, "R10 sig oe off", {15'b0, standby, dout_oe}, 0);
        access(1, 1, 1, 1, 0, 8'h01);
        chk(standby === 1'b1 && dout_oe === '0, "R10 sig ce off", {15'b0, standby, dout_oe}, 32'h10000);
    endtask

    task automatic t_hold;
        logic [DW-1:0] d0, e0;
        access(0, 0, 1, 0, 0, 8'h42);
        d0 = dout; e0 = dout_oe;
        @(posedge clk);
        @(negedge clk);
        chk(dout === d0 && dout_oe === e0 && dout === ref_mem[8'h42], "R11 hold",
            {dout, dout_oe}, {ref_mem[8'h42], 16'hFFFF});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_load;
        t_standby;
        t_disable;
        t_word;
        t_byte;
        t_sig;
        t_sig_ignore;
        t_sig_gated;
        t_hold;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule